// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen User View

This block is a time-of-day and calendar counter kept entirely in packed BCD. It holds two copies of the time. The working copy advances by one second on every cycle in which the `tick` input is high. The user copy is what the byte-wide register port returns. The fields are seconds, minutes, 24-hour hours, weekday, day of month, month, two-digit year and century.

In normal operation the user copy follows the working copy one clock later. Two control bits hold the user copy still. The hold bit freezes it so that software can read a consistent time while the working copy keeps counting. The set bit also freezes it and opens the time fields to writes. Clearing the set bit loads the user copy into the working copy, and counting continues from the loaded value. A stop bit in the seconds register prevents the working copy from advancing. A test-mode flag bit sits in the weekday register.

Register port timing: a write takes effect at the clock edge where `sel` and `we` are both high. Read data is combinational while `sel` and `oe` are high and `we` is low.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, the registers read as follows.
  - Offset 8h reads 20h: set bit 7 = 0, hold bit 6 = 0, century 20.
  - Offset 9h reads 80h: stop bit 7 = 1, seconds 00.
  - Minutes (Ah), hours (Bh) and year (Fh) read 00h.
  - Weekday (Ch, bits 2:0) reads 01h, with test flag bit 6 = 0.
  - Date (Dh) and month (Eh) read 01h.
- R2: While the stop bit (offset 9h, bit 7) is 1, `tick` does not advance the time. The stop bit can be written at any time. Writing it to 0 starts counting.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23, all in BCD, each carrying into the next field on wrap.
- R4: Writing the hold bit (offset 8h, bit 6) to 1 captures the working time at that edge. The user copy then stays constant while the working copy keeps counting.
- R5: After the hold bit is cleared, the user copy shows the working time one clock cycle after the clearing write.
- R6: The set bit behaves as follows.
  - Writes to the time fields at offsets 9h to Fh are ignored while the set bit (offset 8h, bit 7) is 0.
  - While the set bit is 1, those writes are accepted and the user copy is not refreshed.
  - A write to 8h that clears the set bit loads all fields, including the century written with it, into the working copy. Counting resumes from the loaded value.
- R7: The day of month wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February.
- R8: February has 29 days when the year is divisible by 4. For year 00, the century must be divisible by 4 instead. Otherwise February has 28 days.
- R9: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R10: The weekday counts 1 to 7 and wraps to 1 when the hour wraps.
- R11: The test flag (offset Ch, bit 6) can be written at any time, regardless of the set bit, and reads back unchanged.
- R12: `rdata` is 00h unless `sel` and `oe` are high and `we` is low. Offsets 0h to 7h always read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| sel | input | 1 | Register port select |
| we | input | 1 | Write strobe |
| oe | input | 1 | Read enable |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |

## Verification
A wrong carry condition in the working copy shows up at the ports at the first tick that crosses the faulty boundary: one clock cycle after the tick, the user copy shows a wrong day, month or year. A freeze that leaks lets the user copy change between two reads taken while the hold or set bit is 1. A missing transfer appears as stale time after the set bit is cleared. The tests therefore load each boundary time, apply a single tick, and read every field back one cycle later.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sel,
  input  logic       we,
  input  logic       oe,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [7:0] i_sec, i_min, i_hr, i_day, i_date, i_mon, i_yr, i_cent;
  logic [7:0] e_sec, e_min, e_hr, e_day, e_date, e_mon, e_yr, e_cent;
  logic [7:0] n_sec, n_min, n_hr, n_day, n_date, n_mon, n_yr, n_cent;
  logic       osc_stop, ft_bit, w_bit, r_bit;
  logic       leap;
  logic [7:0] last_date;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic div4(input logic [7:0] v);
    logic [5:0] s;
    s = {1'b0, v[7:4], 1'b0} + {2'b00, v[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  wire wr     = sel && we;
  wire xfer   = wr && addr == 4'h8 && w_bit && !wdata[7];
  wire frozen = w_bit || r_bit;
  wire adv    = tick && !osc_stop;

  assign leap = (i_yr == 8'h00) ? div4(i_cent) : div4(i_yr);

  always_comb begin
    case (i_mon)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

  always_comb begin
    n_sec = i_sec; n_min = i_min; n_hr = i_hr; n_day = i_day;
    n_date = i_date; n_mon = i_mon; n_yr = i_yr; n_cent = i_cent;
    if (i_sec != 8'h59) n_sec = inc_bcd(i_sec);
    else begin
      n_sec = 8'h00;
      if (i_min != 8'h59) n_min = inc_bcd(i_min);
      else begin
        n_min = 8'h00;
        if (i_hr != 8'h23) n_hr = inc_bcd(i_hr);
        else begin
          n_hr  = 8'h00;
          n_day = (i_day == 8'h07) ? 8'h01 : inc_bcd(i_day);
          if (i_date != last_date) n_date = inc_bcd(i_date);
          else begin
            n_date = 8'h01;
            if (i_mon != 8'h12) n_mon = inc_bcd(i_mon);
            else begin
              n_mon = 8'h01;
              if (i_yr != 8'h99) n_yr = inc_bcd(i_yr);
              else begin
                n_yr   = 8'h00;
                n_cent = (i_cent == 8'h39) ? 8'h00 : inc_bcd(i_cent);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_sec <= 8'h00; i_min <= 8'h00; i_hr <= 8'h00; i_day <= 8'h01;
      i_date <= 8'h01; i_mon <= 8'h01; i_yr <= 8'h00; i_cent <= 8'h20;
    end else if (xfer) begin
      i_sec <= e_sec; i_min <= e_min; i_hr <= e_hr; i_day <= e_day;
      i_date <= e_date; i_mon <= e_mon; i_yr <= e_yr;
      i_cent <= {2'b00, wdata[5:0]};
    end else if (adv) begin
      i_sec <= n_sec; i_min <= n_min; i_hr <= n_hr; i_day <= n_day;
      i_date <= n_date; i_mon <= n_mon; i_yr <= n_yr; i_cent <= n_cent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_stop <= 1'b1; ft_bit <= 1'b0; w_bit <= 1'b0; r_bit <= 1'b0;
    end else if (wr) begin
      case (addr)
        4'h8: begin w_bit <= wdata[7]; r_bit <= wdata[6]; end
        4'h9: osc_stop <= wdata[7];
        4'hC: ft_bit <= wdata[6];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_sec <= 8'h00; e_min <= 8'h00; e_hr <= 8'h00; e_day <= 8'h01;
      e_date <= 8'h01; e_mon <= 8'h01; e_yr <= 8'h00; e_cent <= 8'h20;
    end else begin
      if (!frozen) begin
        e_sec <= i_sec; e_min <= i_min; e_hr <= i_hr; e_day <= i_day;
        e_date <= i_date; e_mon <= i_mon; e_yr <= i_yr; e_cent <= i_cent;
      end else if (wr && w_bit) begin
        case (addr)
          4'h9: e_sec  <= {1'b0, wdata[6:0]};
          4'hA: e_min  <= {1'b0, wdata[6:0]};
          4'hB: e_hr   <= {2'b00, wdata[5:0]};
          4'hC: e_day  <= {5'b0, wdata[2:0]};
          4'hD: e_date <= {2'b00, wdata[5:0]};
          4'hE: e_mon  <= {3'b000, wdata[4:0]};
          4'hF: e_yr   <= wdata;
          default: ;
        endcase
      end
      if (wr && addr == 4'h8 && (w_bit || wdata[7]))
        e_cent <= {2'b00, wdata[5:0]};
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel && oe && !we) begin
      case (addr)
        4'h8: rdata = {w_bit, r_bit, e_cent[5:0]};
        4'h9: rdata = {osc_stop, e_sec[6:0]};
        4'hA: rdata = {1'b0, e_min[6:0]};
        4'hB: rdata = {2'b00, e_hr[5:0]};
        4'hC: rdata = {1'b0, ft_bit, 3'b000, e_day[2:0]};
        4'hD: rdata = {2'b00, e_date[5:0]};
        4'hE: rdata = {3'b000, e_mon[4:0]};
        4'hF: rdata = e_yr;
        default: rdata = 8'h00;
      endcase
    end
  end

  p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !xfer) |=> $stable(i_sec));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !xfer && i_sec == 8'h59) |=> (i_sec == 8'h00));

  p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_bit && !w_bit) |=> $stable({e_sec, e_min, e_hr, e_day, e_date, e_mon, e_yr}));

  p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_bit && !w_bit) |=> (e_sec == $past(i_sec) && e_yr == $past(i_yr)));

  p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (i_min == $past(e_min) && i_date == $past(e_date)));

endmodule

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic sel = 1'b0, we = 1'b0, oe = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bcd_calendar_clock i_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .we(we), .oe(oe),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_raw(input logic [3:0] a, input logic o, input logic w, output logic [7:0] v);
    sel = 1'b1; oe = o; we = w; addr = a; wdata = 8'h00;
    #1 v = rdata;
    sel = 1'b0; oe = 1'b0; we = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_raw(a, 1'b1, 1'b0, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] c, y, m, d, wd, h, mi, s);
    wr(4'h8, {2'b10, c[5:0]});
    wr(4'hF, y); wr(4'hE, m); wr(4'hD, d); wr(4'hC, wd);
    wr(4'hB, h); wr(4'hA, mi); wr(4'h9, s);
    wr(4'h8, {2'b00, c[5:0]});
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg("R1 ctl/century", 4'h8, 8'h20);
    expect_reg("R1 stop/sec", 4'h9, 8'h80);
    expect_reg("R1 min", 4'hA, 8'h00);
    expect_reg("R1 hour", 4'hB, 8'h00);
    expect_reg("R1 ft/day", 4'hC, 8'h01);
    expect_reg("R1 date", 4'hD, 8'h01);
    expect_reg("R1 month", 4'hE, 8'h01);
    expect_reg("R1 year", 4'hF, 8'h00);
  endtask

  task automatic t_stop();
    pulse_tick(); pulse_tick();
    expect_reg("R2 stopped no advance", 4'h9, 8'h80);
    wr(4'h9, 8'h00);
    pulse_tick();
    expect_reg("R2 running after clear", 4'h9, 8'h01);
  endtask

  task automatic t_hms();
    set_time(8'h20, 8'h05, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R3 sec wrap", 4'h9, 8'h00);
    expect_reg("R3 min wrap", 4'hA, 8'h00);
    expect_reg("R3 hour inc", 4'hB, 8'h10);
    set_time(8'h20, 8'h05, 8'h03, 8'h10, 8'h02, 8'h13, 8'h09, 8'h09);
    pulse_tick();
    expect_reg("R3 bcd sec digit carry", 4'h9, 8'h10);
  endtask

  task automatic t_year_end();
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R3 hour wrap", 4'hB, 8'h00);
    expect_reg("R10 weekday 7->1", 4'hC, 8'h01);
    expect_reg("R9 date wrap", 4'hD, 8'h01);
    expect_reg("R9 month wrap", 4'hE, 8'h01);
    expect_reg("R9 year wrap", 4'hF, 8'h00);
    expect_reg("R9 century inc", 4'h8, 8'h20);
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R9 century 39->00", 4'h8, 8'h00);
    expect_reg("R10 weekday inc", 4'hC, 8'h04);
  endtask

  task automatic t_months();
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R7 april 30 wrap date", 4'hD, 8'h01);
    expect_reg("R7 april 30 wrap month", 4'hE, 8'h05);
    set_time(8'h20, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R7 january 30 -> 31", 4'hD, 8'h31);
    pulse_tick();
    expect_reg("R7 january idle tick", 4'hD, 8'h31);
    set_time(8'h20, 8'h23, 8'h11, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R7 november wrap", 4'hE, 8'h12);
  endtask

  task automatic t_leap();
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8 year 24 feb 29", 4'hD, 8'h29);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8 year 24 feb29 -> mar", 4'hE, 8'h03);
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8 year 23 feb28 -> mar", 4'hE, 8'h03);
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8 century 20 year 00 leap", 4'hD, 8'h29);
    set_time(8'h19, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    expect_reg("R8 century 19 year 00 not leap", 4'hE, 8'h03);
  endtask

  task automatic t_hold_and_set();
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00);
    wr(4'h8, 8'h60);
    pulse_tick(); pulse_tick(); pulse_tick();
    expect_reg("R4 held sec", 4'h9, 8'h00);
    expect_reg("R4 hold bit reads 1", 4'h8, 8'h60);
    wr(4'h8, 8'h20);
    @(negedge clk);
    expect_reg("R5 tracks after release", 4'h9, 8'h03);
    wr(4'hA, 8'h45);
    @(negedge clk);
    expect_reg("R6 write ignored without set bit", 4'hA, 8'h00);
    wr(4'h8, 8'hA0);
    wr(4'hA, 8'h45);
    pulse_tick();
    expect_reg("R6 loaded minutes visible", 4'hA, 8'h45);
    expect_reg("R6 seconds frozen while set", 4'h9, 8'h03);
    wr(4'h8, 8'h21);
    @(negedge clk);
    expect_reg("R6 transfer minutes", 4'hA, 8'h45);
    expect_reg("R6 transfer century", 4'h8, 8'h21);
    pulse_tick();
    expect_reg("R6 counting resumes", 4'h9, 8'h04);
  endtask

  task automatic t_ftest();
    wr(4'hC, 8'h40);
    expect_reg("R11 test flag set, day kept", 4'hC, 8'h43);
    wr(4'hC, 8'h00);
    expect_reg("R11 test flag cleared", 4'hC, 8'h03);
  endtask

  task automatic t_port();
    logic [7:0] v;
    rd_raw(4'hF, 1'b0, 1'b0, v);
    chk("R12 no oe reads 00", v, 8'h00);
    rd_raw(4'hF, 1'b1, 1'b1, v);
    chk("R12 we high reads 00", v, 8'h00);
    expect_reg("R12 low offset reads 00", 4'h3, 8'h00);
    expect_reg("R12 year still readable", 4'hF, 8'h10);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stop();
    t_hms();
    t_year_end();
    t_months();
    t_leap();
    t_hold_and_set();
    t_ftest();
    t_port();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule